// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a system watchdog clocked from a slow clock. A prescaler divides the slow clock into a periodic tick, and a down counter loaded with a timeout value steps once per tick. If software does not restart the counter with a keyed restart strobe before the counter runs out, the block raises a reset pulse for the system reset sequencer. It also sets a sticky flag that shows the watchdog has fired.

The watchdog comes out of reset already armed. It is enabled, reset generation is on, and the timeout is the largest the counter can hold. Software gets exactly one chance to change this. The first write to the mode inputs loads the timeout, the enable and the reset-enable. It can also switch the watchdog off. That write locks the configuration, and every later mode write is ignored until the next reset. With the default prescaler of 128 and a 12-bit counter, a 32.768 kHz slow clock gives a 256 Hz tick and a 16 s maximum period.

Top module: `wdt_lock`

## Requirements
- R1: After reset the block is enabled with reset generation on, the timeout is all ones, `cnt_value` is all ones, and `cfg_locked`, `fired` and `wdt_rst` are 0.
- R2: While enabled, one tick occurs every PRESC_DIV clock cycles. Each tick decrements `cnt_value`. The tick that finds `cnt_value` at 0 is the expiry. Expiry therefore falls exactly (timeout+1)*PRESC_DIV cycles after reset, a taken mode write or an accepted restart.
- R3: On an expiry with reset generation on, `wdt_rst` goes high in the next cycle and stays high for exactly RST_LEN cycles.
- R4: An expiry sets `fired`, which stays 1 until reset. The expiry reloads `cnt_value` with the timeout, and counting continues.
- R5: A restart is accepted when `kick_wr` is 1 and `kick_key` equals KEY (default 8'hA5). It reloads `cnt_value` with the timeout and clears the prescaler.
- R6: A restart strobe with any other key value has no effect on the count or on the expiry time.
- R7: The first mode write after reset takes the timeout, enable and reset-enable values, reloads `cnt_value`, clears the prescaler and sets `cfg_locked`.
- R8: While `cfg_locked` is 1, mode writes change neither the configuration nor the count.
- R9: While disabled, `cnt_value` holds, and neither `fired` nor `wdt_rst` ever rises.
- R10: With reset generation off, an expiry sets `fired` but `wdt_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_timeout | input | CNT_W | Timeout value for the mode write |
| mode_en | input | 1 | Watchdog enable for the mode write |
| mode_rst_en | input | 1 | Reset generation enable for the mode write |
| kick_wr | input | 1 | Restart strobe |
| kick_key | input | KEY_W | Key presented with the restart strobe |
| cnt_value | output | CNT_W | Current counter value |
| cfg_locked | output | 1 | Configuration has been written and is locked |
| fired | output | 1 | Sticky flag that the watchdog has expired |
| wdt_rst | output | 1 | Reset request pulse |

## Verification
The hardest event to reach from the ports is the expiry of the reset-default configuration. No write can shorten that configuration without locking it, so the bench must wait out the full 4096 ticks. To do so it builds the block with a prescaler of 4, which turns the full period into 16384 cycles, and it counts every edge from reset release. The lock is shown at the ports the same way. The bench attempts a later mode write that would disable the watchdog or shorten its period, then measures that the next expiry lands on the cycle predicted from the first write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_KEY_W = 8;
  localparam logic [WDT_KEY_W-1:0] WDT_KEY_DEFAULT = 8'hA5;

  // A restart strobe counts only with the exact key.
  function automatic logic key_match(input logic strobe,
                                     input logic [WDT_KEY_W-1:0] got,
                                     input logic [WDT_KEY_W-1:0] want);
    return strobe && (got == want);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  function automatic logic [PW-1:0] next_phase(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (clr) phase <= '0;
    else if (run) phase <= next_phase(phase);
  end

  AST_PRESC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == '0)); // R5
endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  // On the tick that sees zero, reload; otherwise step down.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] rl);
    return (c == '0) ? rl : c - 1'b1;
  endfunction

  assign expire = tick && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '1;
    else if (load)  count <= load_val;
    else if (tick)  count <= next_count(count, load_val);
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count)); // R9
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_out
);
  localparam int unsigned LW = $clog2(RST_LEN + 1);
  localparam logic [LW-1:0] LEN = LW'(RST_LEN);

  logic [LW-1:0] remain;

  assign pulse_out = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (fire)           remain <= LEN;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  AST_PULSE_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse_out); // R3
endmodule

// File: rtl/wdt_lock.sv
module wdt_lock
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned PRESC_DIV = 128,
  parameter int unsigned RST_LEN   = 4,
  parameter int unsigned KEY_W     = WDT_KEY_W,
  parameter logic [KEY_W-1:0] KEY  = WDT_KEY_DEFAULT
) (
  input  logic             clk_slow,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [CNT_W-1:0] mode_timeout,
  input  logic             mode_en,
  input  logic             mode_rst_en,
  input  logic             kick_wr,
  input  logic [KEY_W-1:0] kick_key,
  output logic [CNT_W-1:0] cnt_value,
  output logic             cfg_locked,
  output logic             fired,
  output logic             wdt_rst
);
  typedef struct packed {
    logic [CNT_W-1:0] timeout;
    logic             en;
    logic             rst_en;
  } cfg_t;

  cfg_t cfg;
  logic locked;

  // Named internal events
  logic             mode_take;
  logic             kick_ok;
  logic             tick;
  logic             expire;
  logic             reload;
  logic [CNT_W-1:0] reload_val;

  assign mode_take  = mode_wr && !locked;
  assign kick_ok    = key_match(kick_wr, kick_key, KEY);
  assign reload     = mode_take || kick_ok;
  assign reload_val = mode_take ? mode_timeout : cfg.timeout;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '{timeout: '1, en: 1'b1, rst_en: 1'b1};
      locked <= 1'b0;
    end else if (mode_take) begin
      cfg    <= '{timeout: mode_timeout, en: mode_en, rst_en: mode_rst_en};
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n)      fired <= 1'b0;
    else if (expire) fired <= 1'b1;
  end

  wdt_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk_slow), .rst_n(rst_n), .run(cfg.en), .clr(reload), .tick(tick)
  );

  wdt_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_slow), .rst_n(rst_n), .tick(tick), .load(reload),
    .load_val(reload_val), .count(cnt_value), .expire(expire)
  );

  wdt_pulse_gen #(.RST_LEN(RST_LEN)) u_pulse (
    .clk(clk_slow), .rst_n(rst_n), .fire(expire && cfg.rst_en), .pulse_out(wdt_rst)
  );

  assign cfg_locked = locked;

  AST_LOCK_STICKY: assert property (@(posedge clk_slow) disable iff (!rst_n)
    locked |=> locked); // R7
  AST_LATE_MODE_IGNORED: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (locked && mode_wr) |=> $stable(cfg)); // R8
  AST_FIRED_STICKY: assert property (@(posedge clk_slow) disable iff (!rst_n)
    fired |=> fired); // R4
  AST_KICK_RELOAD: assert property (@(posedge clk_slow) disable iff (!rst_n)
    (kick_ok && !mode_wr) |=> (cnt_value == cfg.timeout)); // R5
  AST_NO_EXPIRE_DISABLED: assert property (@(posedge clk_slow) disable iff (!rst_n)
    !cfg.en |-> !expire); // R9
endmodule

// File: tb/wdt_lock_test.sv
`timescale 1ns/1ps
module wdt_lock_test;
  localparam int CW  = 12;
  localparam int DIV = 4;
  localparam int RL  = 3;
  localparam logic [7:0] GOOD_KEY = 8'hA5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_wr = 1'b0;
  logic [CW-1:0] mode_timeout = '0;
  logic          mode_en = 1'b0;
  logic          mode_rst_en = 1'b0;
  logic          kick_wr = 1'b0;
  logic [7:0]    kick_key = '0;
  logic [CW-1:0] cnt_value;
  logic          cfg_locked, fired, wdt_rst;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_lock #(.CNT_W(CW), .PRESC_DIV(DIV), .RST_LEN(RL)) uut (
    .clk_slow(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_timeout(mode_timeout),
    .mode_en(mode_en), .mode_rst_en(mode_rst_en), .kick_wr(kick_wr),
    .kick_key(kick_key), .cnt_value(cnt_value), .cfg_locked(cfg_locked),
    .fired(fired), .wdt_rst(wdt_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_mode(input int t, input logic en, input logic re);
    @(negedge clk);
    mode_wr = 1'b1; mode_timeout = CW'(t); mode_en = en; mode_rst_en = re;
    @(posedge clk); #1 mode_wr = 1'b0;
  endtask

  task automatic do_kick(input logic [7:0] key);
    @(negedge clk);
    kick_wr = 1'b1; kick_key = key;
    @(posedge clk); #1 kick_wr = 1'b0;
  endtask

  // Edges counted until wdt_rst is seen high.
  task automatic wait_rst(input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk); #1 n++;
    end while (!wdt_rst && n < limit);
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk("R1 wdt_rst", int'(wdt_rst), 0);
    chk("R1 fired", int'(fired), 0);
    chk("R1 locked", int'(cfg_locked), 0);
    chk("R1 count", int'(cnt_value), 4095);
  endtask

  task automatic t_default_expiry();
    int n, w;
    do_reset();
    // first posedge after release is edge 1
    n = 0;
    do begin @(posedge clk); #1 n++; end while (!wdt_rst && n < 20000);
    chk("R2 default expiry cycles", n, 4096 * DIV);
    chk("R4 fired set", int'(fired), 1);
    chk("R4 reload to timeout", int'(cnt_value), 4095);
    w = 0;
    while (wdt_rst && w < 20) begin w++; @(posedge clk); #1; end
    chk("R3 pulse width", w, RL);
    repeat (10) @(posedge clk);
    #1 chk("R4 fired sticky", int'(fired), 1);
  endtask

  task automatic t_first_write();
    int n;
    do_reset();
    do_mode(10, 1'b1, 1'b1);
    chk("R7 locked", int'(cfg_locked), 1);
    chk("R7 count reloaded", int'(cnt_value), 10);
    wait_rst(500, n);
    chk("R7 expiry after mode write", n, 11 * DIV);
  endtask

  task automatic t_late_write();
    int n;
    do_reset();
    do_mode(10, 1'b1, 1'b1);
    do_mode(2, 1'b0, 1'b1);
    chk("R8 count unchanged", int'(cnt_value), 10);
    wait_rst(500, n);
    chk("R8 late write ignored", n, 11 * DIV - 1);
  endtask

  task automatic t_kicks();
    int n;
    do_reset();
    do_mode(10, 1'b1, 1'b1);
    repeat (20) @(posedge clk);
    do_kick(8'h5A);
    wait_rst(500, n);
    chk("R6 bad key ignored", n, 11 * DIV - 21);
    do_reset();
    do_mode(10, 1'b1, 1'b1);
    repeat (21) @(posedge clk);
    do_kick(GOOD_KEY);
    chk("R5 kick reload", int'(cnt_value), 10);
    wait_rst(500, n);
    chk("R5 expiry after kick", n, 11 * DIV);
  endtask

  task automatic t_disabled();
    int seen;
    do_reset();
    do_mode(7, 1'b0, 1'b1);
    seen = 0;
    repeat (300) begin @(posedge clk); #1 if (wdt_rst || fired) seen++; end
    chk("R9 no reset or fired", seen, 0);
    chk("R9 count holds", int'(cnt_value), 7);
    do_mode(7, 1'b1, 1'b1);
    seen = 0;
    repeat (300) begin @(posedge clk); #1 if (wdt_rst || fired) seen++; end
    chk("R8 enable after lock ignored", seen, 0);
    chk("R8 count still holds", int'(cnt_value), 7);
  endtask

  task automatic t_no_reset_gen();
    int n, seen;
    do_reset();
    do_mode(5, 1'b1, 1'b0);
    n = 0; seen = 0;
    do begin
      @(posedge clk); #1 n++;
      if (wdt_rst) seen++;
    end while (!fired && n < 500);
    chk("R10 fired time", n, 6 * DIV);
    repeat (10) begin @(posedge clk); #1 if (wdt_rst) seen++; end
    chk("R10 no reset pulse", seen, 0);
  endtask

  initial begin
    t_reset_state();
    t_default_expiry();
    t_first_write();
    t_late_write();
    t_kicks();
    t_disabled();
    t_no_reset_gen();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule